// File: doc/BRIEF.md
# Vectored Peripheral Interrupt Controller

This controller gathers interrupt requests from up to 31 on-chip communication peripherals and presents one cascaded request line to the processor. Each request line is latched into a pending bit. A per-source enable mask gates the pending bits. A priority picker then selects the most urgent source that is pending, enabled and not already being serviced. Vector 0 is not tied to any peripheral. It is reserved for an error condition, raised when a peripheral asserts its request in the same cycle that software disables it.

Software talks to the block through a small register port with four registers. A write of 1 to the acknowledge bit of the vector register captures the current winner and marks it in service. A read of the same register returns that vector in bits [15:11]. Service ends when software writes 1 to the vector's bit in the in-service register. The configuration register holds the global enable, an output request level, a source promoted above all others, and a map that places the four serial-channel sources into four priority slots.

Top module: `periph_irq_ctrl`

## Requirements
- R1: After reset, the mask, in-service and vector registers read 0 and the cascade request is low. The configuration register reads 0x00E40000, which is the identity slot map with everything else cleared.
- R2: A request that is high at a clock edge sets that source's pending bit. The bit stays set after the request drops and is cleared only by an end-of-service write to that vector.
- R3: Mask register (address 1) bit v at 1 enables source v and at 0 blocks it. A blocked pending source does not drive the cascade request and cannot be acknowledged. The register reads back as written.
- R4: The cascade request stays low while configuration bit 31 (global enable) is 0, even if sources are pending and enabled.
- R5: A write to the vector register (address 3) with bit 0 set acknowledges the current winner. A later read of that register returns the winner in bits [15:11], with all other bits 0, and the winner's bit in the in-service register (address 2) is set.
- R6: A source that is in service is not selected again. Writing 1 to bit v of the in-service register clears in-service bit v and pending bit v. Bits written with 0 are unchanged.
- R7: Among eligible sources with no promotion or remapping in effect, the higher vector number wins.
- R8: Configuration bits [4:0] name one source that wins over every other eligible source.
- R9: The serial-channel sources are vectors 30, 29, 28 and 27, called channels 0 to 3. Configuration bits [17+2c:16+2c] place channel c into slot 0 to 3. Slot s ranks as vector 30 - s would.
- R10: When a source's request is high in the same cycle that a mask write drops that source's enable, error vector 0 becomes pending. The error vector is always enabled, whatever mask bit 0 holds.
- R11: An acknowledge with no eligible source returns vector 0 and leaves the in-service register unchanged.
- R12: The request level output equals twice the value of configuration bits [15:13].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_req_i | input | 31 | Peripheral request lines for vectors 31 down to 1 |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select: 0 configuration, 1 mask, 2 in-service, 3 vector |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Cascaded request to the processor |
| irq_level_o | output | 4 | Level at which the cascaded request is presented |

## Verification
Every state element takes a single register stage. A request, a mask or configuration write, an acknowledge or an end-of-service write that is applied before edge N is visible on irq_o, on irq_level_o and through a read of rdata_o once edge N has passed. The bench drives its inputs on the falling edge and holds them across exactly one rising edge. It samples at the next falling edge, so each result is checked one edge after its stimulus. The acknowledge result is checked through a read of the vector register made after the acknowledge edge. That read samples the captured winner and never the live choice of the picker.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

  typedef enum logic [1:0] {
    REG_CFG  = 2'd0,
    REG_MASK = 2'd1,
    REG_ISR  = 2'd2,
    REG_VEC  = 2'd3
  } reg_sel_e;

  localparam int CFG_TOP_LSB = 0;
  localparam int CFG_LVL_LSB = 13;
  localparam int CFG_LVL_W   = 3;
  localparam int CFG_MAP_LSB = 16;
  localparam int CFG_EN_BIT  = 31;
  localparam int VEC_LSB     = 11;
  localparam int ACK_BIT     = 0;

  // identity placement: channel c sits in slot c
  function automatic logic [31:0] ident_map(int nser, int sw);
    logic [31:0] m;
    m = '0;
    for (int c = 0; c < nser; c++) m[c*sw +: 8] = 8'(c);
    return m;
  endfunction

endpackage

// File: rtl/pirq_src_bank.sv
module pirq_src_bank #(
  parameter int NSRC = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] eoi_i,
  input  logic [NSRC-1:0] take_i,
  output logic [NSRC-1:0] pend_o,
  output logic [NSRC-1:0] insvc_o
);

  for (genvar v = 0; v < NSRC; v++) begin : g_src
    logic pend_q, isvc_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q <= 1'b0;
        isvc_q <= 1'b0;
      end else begin
        pend_q <= (pend_q | set_i[v]) & ~eoi_i[v];
        isvc_q <= (isvc_q & ~eoi_i[v]) | take_i[v];
      end
    end

    assign pend_o[v]  = pend_q;
    assign insvc_o[v] = isvc_q;

    a_r2_pend_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_q && !eoi_i[v]) |=> pend_q);

    a_r6_eoi_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (eoi_i[v] && !take_i[v]) |=> (!isvc_q && !pend_q));
  end

endmodule

// File: rtl/pirq_pick.sv
module pirq_pick #(
  parameter int NSRC    = 32,
  parameter int NSER    = 4,
  parameter int SER_TOP = 30,
  localparam int VW     = $clog2(NSRC),
  localparam int RW     = VW + 1,
  localparam int SW     = $clog2(NSER),
  localparam int MW     = NSER * SW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] elig_i,
  input  logic [VW-1:0]   top_src_i,
  input  logic [MW-1:0]   slot_map_i,
  output logic            valid_o,
  output logic [VW-1:0]   vec_o
);

  // rank of a vector: promoted source outranks all; serial channels
  // take the rank of their slot; everything else ranks by number
  function automatic logic [RW-1:0] rank_of(int v, logic [VW-1:0] top,
                                            logic [MW-1:0] map);
    logic [RW-1:0] r;
    r = RW'(v);
    for (int c = 0; c < NSER; c++)
      if (v == SER_TOP - c) r = RW'(SER_TOP - int'(map[c*SW +: SW]));
    if (VW'(v) == top) r = RW'(NSRC);
    return r;
  endfunction

  logic [RW+VW-1:0] best_key, cur_key;

  always_comb begin
    best_key = '0;
    cur_key  = '0;
    valid_o  = 1'b0;
    vec_o    = '0;
    for (int v = 0; v < NSRC; v++) begin
      if (elig_i[v]) begin
        cur_key = {rank_of(v, top_src_i, slot_map_i), VW'(v)};
        if (!valid_o || cur_key > best_key) begin
          best_key = cur_key;
          vec_o    = VW'(v);
          valid_o  = 1'b1;
        end
      end
    end
  end

  a_r7_pick_eligible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> elig_i[vec_o]);

  a_r7_none_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(elig_i) == 0) |-> !valid_o);

endmodule

// File: rtl/periph_irq_ctrl.sv
module periph_irq_ctrl
  import pirq_pkg::*;
#(
  parameter int NSRC    = 32,
  parameter int NSER    = 4,
  parameter int SER_TOP = 30,
  localparam int VW     = $clog2(NSRC),
  localparam int SW     = $clog2(NSER),
  localparam int MW     = NSER * SW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:1] src_req_i,
  input  logic            wr_en_i,
  input  logic [1:0]      addr_i,
  input  logic [31:0]     wdata_i,
  output logic [31:0]     rdata_o,
  output logic            irq_o,
  output logic [3:0]      irq_level_o
);

  localparam logic [MW-1:0] MAP_RST = MW'(ident_map(NSER, SW));

  logic                 en_q;
  logic [CFG_LVL_W-1:0] lvl_q;
  logic [MW-1:0]        map_q;
  logic [VW-1:0]        top_q;
  logic [NSRC-1:0]      mask_q;
  logic [VW-1:0]        vec_q;

  logic cfg_wr, mask_wr, isr_wr, vec_wr, ack_fire;
  logic [NSRC-1:0] wbits, mask_drop, set_vec, eoi_vec, take_vec;
  logic [NSRC-1:0] pend, insvc, elig;
  logic            race, pick_valid;
  logic [VW-1:0]   pick_vec;

  assign wbits    = wdata_i[NSRC-1:0];
  assign cfg_wr   = wr_en_i && (addr_i == REG_CFG);
  assign mask_wr  = wr_en_i && (addr_i == REG_MASK);
  assign isr_wr   = wr_en_i && (addr_i == REG_ISR);
  assign vec_wr   = wr_en_i && (addr_i == REG_VEC);
  assign ack_fire = vec_wr && wdata_i[ACK_BIT];

  // enable bits being dropped while that source is requesting
  assign mask_drop = mask_wr ? (mask_q & ~wbits) : '0;
  assign race      = |(mask_drop & {src_req_i, 1'b0});
  assign set_vec   = {src_req_i, race};
  assign eoi_vec   = isr_wr ? wbits : '0;
  assign take_vec  = (ack_fire && pick_valid) ? (NSRC'(1) << pick_vec) : '0;

  // error vector is always enabled
  assign elig = pend & (mask_q | NSRC'(1)) & ~insvc;

  pirq_src_bank #(.NSRC(NSRC)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_vec),
    .eoi_i   (eoi_vec),
    .take_i  (take_vec),
    .pend_o  (pend),
    .insvc_o (insvc)
  );

  pirq_pick #(.NSRC(NSRC), .NSER(NSER), .SER_TOP(SER_TOP)) u_pick (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .elig_i     (elig),
    .top_src_i  (top_q),
    .slot_map_i (map_q),
    .valid_o    (pick_valid),
    .vec_o      (pick_vec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      lvl_q  <= '0;
      map_q  <= MAP_RST;
      top_q  <= '0;
      mask_q <= '0;
      vec_q  <= '0;
    end else begin
      if (cfg_wr) begin
        en_q  <= wdata_i[CFG_EN_BIT];
        lvl_q <= wdata_i[CFG_LVL_LSB +: CFG_LVL_W];
        map_q <= wdata_i[CFG_MAP_LSB +: MW];
        top_q <= wdata_i[CFG_TOP_LSB +: VW];
      end
      if (mask_wr) mask_q <= wbits;
      if (ack_fire) vec_q <= pick_valid ? pick_vec : '0;
    end
  end

  assign irq_o       = en_q & (|elig);
  assign irq_level_o = {lvl_q, 1'b0};

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_CFG: begin
        rdata_o[CFG_EN_BIT]                 = en_q;
        rdata_o[CFG_LVL_LSB +: CFG_LVL_W]   = lvl_q;
        rdata_o[CFG_MAP_LSB +: MW]          = map_q;
        rdata_o[CFG_TOP_LSB +: VW]          = top_q;
      end
      REG_MASK: rdata_o[NSRC-1:0]     = mask_q;
      REG_ISR:  rdata_o[NSRC-1:0]     = insvc;
      default:  rdata_o[VEC_LSB +: VW] = vec_q;
    endcase
  end

  a_r5_ack_records: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_fire && pick_valid) |=> (insvc[vec_q] && vec_q == $past(pick_vec)));

  a_r11_ack_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_fire && !pick_valid) |=> (vec_q == '0 && insvc == $past(insvc)));

  a_r10_race_error: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (race && !eoi_vec[0]) |=> pend[0]);

  a_r4_gate_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> !irq_o);

endmodule

// File: tb/periph_irq_ctrl_tb.sv
`timescale 1ns/1ps
module periph_irq_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:1] src = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic [3:0]  lvl;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  localparam logic [31:0] EN = 32'h8000_0000;
  localparam logic [31:0] IDMAP = 32'h00E4_0000;

  always #2.5 clk = ~clk;

  periph_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_req_i(src), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
    .irq_level_o(lvl)
  );

  function automatic logic [31:0] vfield(int v);
    return 32'(v) << 11;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #0.5 d = rdata;
  endtask

  task automatic pulse(logic [31:1] bits);
    @(negedge clk);
    src = bits;
    @(negedge clk);
    src = '0;
  endtask

  task automatic ack_expect(string tag, int v);
    logic [31:0] d;
    wr(2'd3, 32'h1);
    rd(2'd3, d);
    check(tag, d, vfield(v));
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(2'd0, d); check("R1 cfg", d, IDMAP);
    rd(2'd1, d); check("R1 mask", d, 0);
    rd(2'd2, d); check("R1 isr", d, 0);
    rd(2'd3, d); check("R1 vec", d, 0);
    check("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_basic;
    logic [31:0] d;
    wr(2'd1, 32'h20);
    pulse(31'h10);                      // source 5 (bit 5 of src[31:1])
    @(negedge clk); check("R4 disabled", 32'(irq), 0);
    wr(2'd0, EN | IDMAP);
    @(negedge clk); check("R4 enabled", 32'(irq), 1);
    wr(2'd1, 32'h0);
    @(negedge clk); check("R3 masked irq", 32'(irq), 0);
    rd(2'd1, d); check("R3 readback", d, 0);
    wr(2'd1, 32'h20);
    @(negedge clk); check("R2 pending held", 32'(irq), 1);
    ack_expect("R5 vector", 5);
    rd(2'd2, d); check("R5 isr", d, 32'h20);
    check("R6 no reselect", 32'(irq), 0);
    wr(2'd2, 32'h0);
    rd(2'd2, d); check("R6 zero write", d, 32'h20);
    wr(2'd2, 32'h20);
    rd(2'd2, d); check("R6 eoi isr", d, 0);
    check("R6 eoi pending", 32'(irq), 0);
  endtask

  task automatic t_prio;
    logic [31:0] d;
    wr(2'd1, (32'h1 << 3) | (32'h1 << 9) | (32'h1 << 20));
    pulse((31'h1 << 2) | (31'h1 << 8) | (31'h1 << 19));
    ack_expect("R7 first", 20);
    ack_expect("R7 second", 9);
    ack_expect("R7 third", 3);
    ack_expect("R11 empty vec", 0);
    rd(2'd2, d); check("R11 isr kept", d, 32'h0010_0208);
    wr(2'd2, 32'h0010_0208);
    @(negedge clk); check("R6 all cleared", 32'(irq), 0);
  endtask

  task automatic t_top;
    wr(2'd0, EN | IDMAP | 32'd3);
    pulse((31'h1 << 2) | (31'h1 << 19));
    ack_expect("R8 promoted", 3);
    wr(2'd2, 32'h8);
    ack_expect("R8 next", 20);
    wr(2'd2, 32'h0010_0000);
    wr(2'd0, EN | IDMAP);
  endtask

  task automatic t_slots;
    wr(2'd1, 32'h7800_0000);            // vectors 27..30
    pulse((31'h1 << 29) | (31'h1 << 26));
    ack_expect("R9 default map", 30);
    ack_expect("R9 default next", 27);
    wr(2'd2, 32'h4800_0000);
    wr(2'd0, EN | 32'h0027_0000);       // ch0->3 ch1->1 ch2->2 ch3->0
    pulse((31'h1 << 29) | (31'h1 << 28) | (31'h1 << 26));
    ack_expect("R9 slot A", 27);
    ack_expect("R9 slot B", 29);
    ack_expect("R9 slot D", 30);
    wr(2'd2, 32'h6800_0000);
    wr(2'd0, EN | IDMAP);
  endtask

  task automatic t_race;
    logic [31:0] d;
    wr(2'd1, 32'h1000);
    @(negedge clk);
    src = 31'h1 << 11;                  // source 12
    wr_en = 1'b1; addr = 2'd1; wdata = 32'h0;
    @(negedge clk);
    src = '0; wr_en = 1'b0;
    check("R10 error irq", 32'(irq), 1);
    ack_expect("R10 error vector", 0);
    rd(2'd2, d); check("R10 isr bit0", d, 32'h1);
    check("R3 source 12 blocked", 32'(irq), 0);
    wr(2'd2, 32'h1001);
    wr(2'd1, 32'h1000);
    @(negedge clk); check("R6 pending 12 cleared", 32'(irq), 0);
    wr(2'd1, 32'h0);
  endtask

  task automatic t_level;
    wr(2'd0, EN | IDMAP | (32'd5 << 13));
    @(negedge clk); check("R12 level", 32'(lvl), 10);
    wr(2'd0, EN | IDMAP | (32'd7 << 13));
    @(negedge clk); check("R12 level max", 32'(lvl), 14);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_prio();
    t_top();
    t_slots();
    t_race();
    t_level();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog all actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule